// File: doc/BRIEF.md
# Read-Back Verified Row Write Controller

This controller sits between a fast processor and a slow, low-leakage row memory of 52 rows by 40 bits. It does not allot a write a fixed number of cycles. Once it accepts a write, it drives the row write-enable with the held row address and data, reads the row back on every cycle, and compares the result with the data being written. It reports completion only after the compare has matched and a further margin has passed with the compare still matching. The margin is needed because the read-back path senses only one side of the cell.

The margin length comes from a delay-line tap input and is counted in clock cycles. The tap value is captured when the write is accepted. A mismatch during the margin sends the controller back to waiting for a first match. A busy-cycle limit ends a write that never verifies and raises an error flag. Reads take one cycle. While a write is in progress the ready output is low, so a processor that holds a read request is stalled until the write completes. Any request made while busy is dropped.

Top module: `wv_mem_ctrl`

## Requirements
- R1: After reset, and after reset is applied in the middle of a write, cpu_ready is 1 and cpu_err, cpu_rvalid and mem_wen are 0.
- R2: A write request (cpu_req=1, cpu_we=1, row below 52) seen with cpu_ready=1 is accepted on that clock edge. From the next cycle until completion, cpu_ready is 0, mem_wen is 1, and mem_addr and mem_wdata hold the accepted row and data unchanged.
- R3: A write completes at the clock edge that ends the (T+1)-th consecutive busy cycle in which mem_rdata equals the write data, where T is the value on dly_tap at acceptance (0 to 15). cpu_ready is 1 from the next cycle. With a memory that updates the row after L busy cycles, a row that held different data gives L+1+T busy cycles, and a row that already held the data gives 1+T.
- R4: A mismatching compare during the margin discards the matches counted so far. Completion then needs T+1 new consecutive matches.
- R5: If a write has not completed after TIMEOUT busy cycles (default 255), cpu_ready returns to 1 and cpu_err is set. cpu_err is cleared by the next accepted request.
- R6: Requests made while cpu_ready is 0 are ignored. A write to another row issued during a busy period leaves that row unchanged.
- R7: A read request (cpu_req=1, cpu_we=0, row below 52) seen with cpu_ready=1 returns the row on cpu_rdata, with cpu_rvalid=1, in the next cycle. cpu_ready stays 1 for reads. A read held during a write is served only after the write completes.
- R8: Requests to rows 52 to 63 are ignored. cpu_ready stays 1, cpu_rvalid stays 0, and no write starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor request |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 6 | Row number |
| cpu_wdata | input | 40 | Write data |
| dly_tap | input | 4 | Margin length in cycles, captured at write acceptance |
| cpu_ready | output | 1 | Idle and able to accept a request |
| cpu_rdata | output | 40 | Read data |
| cpu_rvalid | output | 1 | cpu_rdata valid, one cycle |
| cpu_err | output | 1 | Last write timed out without verifying |
| mem_addr | output | 6 | Row address to the memory |
| mem_wen | output | 1 | Row write drive, held for the whole write |
| mem_wdata | output | 40 | Data driven into the row |
| mem_rdata | input | 40 | Combinational read-back of the row at mem_addr |

## Verification
On every cycle, the assertions check four things. First, the row and data stay stable while a write is pending. Second, each completion is preceded by exactly the captured margin plus one of consecutive matching compares. Third, an error appears only after exactly TIMEOUT busy cycles. Fourth, read-valid and out-of-range requests behave as required. Other behaviour can only be shown by the bench's scenarios, because it depends on the memory model:
- the total busy length for various write latencies and tap values;
- a restart caused by a glitch injected into the read-back;
- a rewrite of data already present;
- requests dropped while busy, with the affected row then read back;
- a read stalled behind a write;
- a reset applied during a write.

// File: rtl/wv_pkg.sv
package wv_pkg;

    localparam int DATA_W    = 40;
    localparam int ROW_COUNT = 52;
    localparam int ADDR_W    = $clog2(ROW_COUNT);
    localparam int TAP_W     = 4;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_VERIFY,
        ST_MARGIN
    } wv_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] row;
        logic [DATA_W-1:0] data;
        logic [TAP_W-1:0]  tap;
    } wv_job_t;

    function automatic logic row_in_range(input logic [ADDR_W-1:0] a, input int rows);
        return int'(a) < rows;
    endfunction

endpackage

// File: rtl/wv_cmp.sv
module wv_cmp #(
    parameter int W    = 40,
    parameter int LANE = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         eq
);
    localparam int NL = (W + LANE - 1) / LANE;

    logic [NL-1:0] lane_eq;

    for (genvar i = 0; i < NL; i++) begin : g_lane
        localparam int LO = i * LANE;
        localparam int HI = ((i + 1) * LANE > W) ? W - 1 : (i + 1) * LANE - 1;
        assign lane_eq[i] = (a[HI:LO] == b[HI:LO]);
    end

    assign eq = &lane_eq;
endmodule

// File: rtl/wv_margin_cnt.sv
module wv_margin_cnt #(
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          inc,
    input  logic [TW-1:0] tap,
    output logic          last
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign last = (cnt == tap - 1'b1);
endmodule

// File: rtl/wv_timeout.sv
module wv_timeout #(
    parameter int TIMEOUT = 255
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(TIMEOUT + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (run && cnt != CW'(TIMEOUT - 1)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = run && (cnt == CW'(TIMEOUT - 1));
endmodule

// File: rtl/wv_seq.sv
module wv_seq
    import wv_pkg::*;
#(
    parameter int ROWS = ROW_COUNT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic [TAP_W-1:0]  dly_tap,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              match,
    input  logic              margin_last,
    input  logic              tmr_expired,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_rvalid,
    output logic              cpu_err,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_wen,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [TAP_W-1:0]  job_tap,
    output logic              margin_clr,
    output logic              margin_inc,
    output logic              tmr_clr,
    output logic              tmr_run
);
    wv_state_e state;
    wv_job_t   job;
    logic      busy, take, acc_wr, acc_rd, finish;

    assign busy   = (state != ST_IDLE);
    assign take   = (state == ST_IDLE) && cpu_req && row_in_range(cpu_addr, ROWS);
    assign acc_wr = take && cpu_we;
    assign acc_rd = take && !cpu_we;

    assign finish = ((state == ST_VERIFY) && match && (job.tap == '0)) ||
                    ((state == ST_MARGIN) && match && margin_last);

    assign margin_clr = (state != ST_MARGIN);
    assign margin_inc = (state == ST_MARGIN) && match;
    assign tmr_clr    = !busy;
    assign tmr_run    = busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            job        <= '0;
            cpu_rvalid <= 1'b0;
            cpu_rdata  <= '0;
            cpu_err    <= 1'b0;
        end else begin
            cpu_rvalid <= acc_rd;
            if (acc_rd) begin
                cpu_rdata <= mem_rdata;
            end
            if (acc_wr || acc_rd) begin
                cpu_err <= 1'b0;
            end
            unique case (state)
                ST_IDLE: begin
                    if (acc_wr) begin
                        job.row  <= cpu_addr;
                        job.data <= cpu_wdata;
                        job.tap  <= dly_tap;
                        state    <= ST_VERIFY;
                    end
                end
                ST_VERIFY: begin
                    if (finish) begin
                        state <= ST_IDLE;
                    end else if (tmr_expired) begin
                        state   <= ST_IDLE;
                        cpu_err <= 1'b1;
                    end else if (match) begin
                        state <= ST_MARGIN;
                    end
                end
                ST_MARGIN: begin
                    if (finish) begin
                        state <= ST_IDLE;
                    end else if (tmr_expired) begin
                        state   <= ST_IDLE;
                        cpu_err <= 1'b1;
                    end else if (!match) begin
                        state <= ST_VERIFY;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign cpu_ready = !busy;
    assign mem_wen   = busy;
    assign mem_addr  = busy ? job.row : cpu_addr;
    assign mem_wdata = job.data;
    assign job_tap   = job.tap;
endmodule

// File: rtl/wv_mem_ctrl.sv
module wv_mem_ctrl
    import wv_pkg::*;
#(
    parameter int ROWS    = ROW_COUNT,
    parameter int TIMEOUT = 255
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic [TAP_W-1:0]  dly_tap,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_rvalid,
    output logic              cpu_err,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_wen,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);
    logic             match, margin_last, tmr_expired;
    logic             margin_clr, margin_inc, tmr_clr, tmr_run;
    logic [TAP_W-1:0] job_tap;

    wv_seq #(.ROWS(ROWS)) seq_i (
        .clk(clk), .rst(rst),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .dly_tap(dly_tap), .mem_rdata(mem_rdata),
        .match(match), .margin_last(margin_last), .tmr_expired(tmr_expired),
        .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata), .cpu_rvalid(cpu_rvalid),
        .cpu_err(cpu_err), .mem_addr(mem_addr), .mem_wen(mem_wen),
        .mem_wdata(mem_wdata), .job_tap(job_tap),
        .margin_clr(margin_clr), .margin_inc(margin_inc),
        .tmr_clr(tmr_clr), .tmr_run(tmr_run)
    );

    wv_cmp #(.W(DATA_W)) cmp_i (
        .a(mem_rdata), .b(mem_wdata), .eq(match)
    );

    wv_margin_cnt #(.TW(TAP_W)) margin_i (
        .clk(clk), .rst(rst), .clr(margin_clr), .inc(margin_inc),
        .tap(job_tap), .last(margin_last)
    );

    wv_timeout #(.TIMEOUT(TIMEOUT)) tmr_i (
        .clk(clk), .rst(rst), .clr(tmr_clr), .run(tmr_run),
        .expired(tmr_expired)
    );
endmodule

// File: rtl/wv_mem_ctrl_chk.sv
module wv_mem_ctrl_chk
    import wv_pkg::*;
#(
    parameter int ROWS    = ROW_COUNT,
    parameter int TIMEOUT = 255
) (
    input logic              clk,
    input logic              rst,
    input logic              cpu_req,
    input logic              cpu_we,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic [TAP_W-1:0]  dly_tap,
    input logic              cpu_ready,
    input logic              cpu_rvalid,
    input logic              cpu_err,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_wen,
    input logic [DATA_W-1:0] mem_wdata,
    input logic [DATA_W-1:0] mem_rdata
);
    localparam int BW = $clog2(TIMEOUT + 2);

    logic [BW-1:0]    busy_cnt;
    logic [TAP_W:0]   run;
    logic [TAP_W-1:0] tap_l;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_cnt <= '0;
            run      <= '0;
            tap_l    <= '0;
        end else begin
            busy_cnt <= cpu_ready ? '0 : busy_cnt + 1'b1;
            run      <= (!cpu_ready && mem_rdata == mem_wdata) ? run + 1'b1 : '0;
            if (cpu_ready && cpu_req && cpu_we && int'(cpu_addr) < ROWS) begin
                tap_l <= dly_tap;
            end
        end
    end

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!cpu_ready && $past(!cpu_ready)) |-> ($stable(mem_addr) && $stable(mem_wdata) && mem_wen)); // R2

    AST_MARGIN_RUN: assert property (@(posedge clk) disable iff (rst)
        ($rose(cpu_ready) && !cpu_err) |-> (run == {1'b0, tap_l} + 1'b1)); // R3

    AST_TIMEOUT_LEN: assert property (@(posedge clk) disable iff (rst)
        $rose(cpu_err) |-> (busy_cnt == BW'(TIMEOUT))); // R5

    AST_RVALID_SRC: assert property (@(posedge clk) disable iff (rst)
        cpu_rvalid |-> $past(cpu_ready && cpu_req && !cpu_we)); // R7

    AST_BAD_ROW: assert property (@(posedge clk) disable iff (rst)
        (cpu_ready && cpu_req && int'(cpu_addr) >= ROWS) |=> (cpu_ready && !cpu_rvalid)); // R8
endmodule

bind wv_mem_ctrl wv_mem_ctrl_chk #(.ROWS(ROWS), .TIMEOUT(TIMEOUT)) chk_i (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .dly_tap(dly_tap), .cpu_ready(cpu_ready),
    .cpu_rvalid(cpu_rvalid), .cpu_err(cpu_err), .mem_addr(mem_addr),
    .mem_wen(mem_wen), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
);

// File: tb/wv_mem_ctrl_tb_top.sv
`timescale 1ns/1ps
module wv_mem_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [5:0]  cpu_addr = '0;
    logic [39:0] cpu_wdata = '0;
    logic [3:0]  dly_tap = 4'd4;
    logic        cpu_ready, cpu_rvalid, cpu_err, mem_wen;
    logic [39:0] cpu_rdata, mem_wdata, mem_rdata;
    logic [5:0]  mem_addr;

    int          checks = 0, errors = 0;
    bit          done = 0;

    // memory model: row lands after wlat_r edges of held write drive
    logic [39:0] mem [52];
    int          wcnt = 0, wlat_r = 1;
    bit          stuck_r = 0;
    logic [39:0] glitch = '0;

    always #4 clk = ~clk;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 52; i++) mem[i] <= '0;
            wcnt <= 0;
        end else if (mem_wen) begin
            if (!stuck_r && wcnt == wlat_r - 1 && mem_addr < 6'd52) mem[mem_addr] <= mem_wdata;
            wcnt <= wcnt + 1;
        end else begin
            wcnt <= 0;
        end
    end

    assign mem_rdata = ((mem_addr < 6'd52) ? mem[mem_addr] : 40'h0) ^ glitch;

    wv_mem_ctrl dut_i (
        .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .dly_tap(dly_tap),
        .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata), .cpu_rvalid(cpu_rvalid),
        .cpu_err(cpu_err), .mem_addr(mem_addr), .mem_wen(mem_wen),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // mode: 0 plain, 1 side write during busy, 2 held read, 3 glitch at gk, 4 stuck memory
    task automatic run_write(input logic [5:0] a, input logic [39:0] d, input int wlat,
                             input int tap, input int mode, input int gk,
                             input int exp_busy, input logic exp_err, input string tag);
        int busy;
        bit rv_seen;
        @(negedge clk);
        wlat_r = wlat; stuck_r = (mode == 4);
        cpu_req = 1; cpu_we = 1; cpu_addr = a; cpu_wdata = d; dly_tap = 4'(tap);
        @(negedge clk);
        cpu_req = 0;
        busy = 0; rv_seen = 0;
        while (!cpu_ready && busy < 1000) begin
            busy++;
            glitch = (mode == 3 && busy == gk) ? 40'h1 : 40'h0;
            if (mode == 1) begin
                cpu_req = (busy == 2 || busy == 3); cpu_we = 1;
                cpu_addr = 6'd40; cpu_wdata = 40'hDEAD_BEEF_00;
            end
            if (mode == 2 && busy == 2) begin
                cpu_req = 1; cpu_we = 0; cpu_addr = a;
            end
            if (cpu_rvalid) rv_seen = 1;
            @(negedge clk);
        end
        glitch = '0; stuck_r = 0;
        chk(busy == exp_busy, {tag, " busy length"}, 64'(busy), 64'(exp_busy));
        chk(cpu_err == exp_err, {tag, " error flag"}, 64'(cpu_err), 64'(exp_err));
        if (mode == 2) begin
            chk(!rv_seen, "R7 no read data while write pending", 64'(rv_seen), 64'd0);
            @(negedge clk);
            cpu_req = 0;
            chk(cpu_rvalid == 1'b1, "R7 stalled read served", 64'(cpu_rvalid), 64'd1);
            chk(cpu_rdata == d, "R7 stalled read data", 64'(cpu_rdata), 64'(d));
        end
    endtask

    task automatic do_read(input logic [5:0] a, input logic exp_v, input logic [39:0] exp_d, input string tag);
        @(negedge clk);
        cpu_req = 1; cpu_we = 0; cpu_addr = a;
        @(negedge clk);
        cpu_req = 0;
        chk(cpu_rvalid == exp_v, {tag, " read valid"}, 64'(cpu_rvalid), 64'(exp_v));
        chk(cpu_ready == 1'b1, {tag, " ready during read"}, 64'(cpu_ready), 64'd1);
        if (exp_v) chk(cpu_rdata == exp_d, {tag, " read data"}, 64'(cpu_rdata), 64'(exp_d));
    endtask

    // addr, data, write latency, tap, expected busy cycles
    localparam logic [73:0] VEC [6] = '{
        {6'd0,  40'hA5A5A5A5A5, 8'd3,  4'd4,  16'd8},
        {6'd51, 40'h123456789A, 8'd1,  4'd4,  16'd6},
        {6'd10, 40'hFFFFFFFFFF, 8'd6,  4'd0,  16'd7},
        {6'd10, 40'hFFFFFFFFFF, 8'd6,  4'd2,  16'd3},
        {6'd20, 40'h0000000001, 8'd2,  4'd15, 16'd18},
        {6'd33, 40'h8000000000, 8'd10, 4'd7,  16'd18}
    };

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk(cpu_ready == 1'b1, "R1 ready after reset", 64'(cpu_ready), 64'd1);
        chk(cpu_err == 1'b0, "R1 err after reset", 64'(cpu_err), 64'd0);
        chk(cpu_rvalid == 1'b0, "R1 rvalid after reset", 64'(cpu_rvalid), 64'd0);
        chk(mem_wen == 1'b0, "R1 wen after reset", 64'(mem_wen), 64'd0);

        // R3 table walk, each row read back after its write
        for (int i = 0; i < 6; i++) begin
            run_write(VEC[i][73:68], VEC[i][67:28], int'(VEC[i][27:20]), int'(VEC[i][19:16]),
                      0, 0, int'(VEC[i][15:0]), 1'b0, "R3");
            do_read(VEC[i][73:68], 1'b1, VEC[i][67:28], "R3");
        end

        // R4 glitch inside the margin window restarts the count
        run_write(6'd2, 40'h0F0F0F0F0F, 3, 4, 3, 6, 11, 1'b0, "R4");
        do_read(6'd2, 1'b1, 40'h0F0F0F0F0F, "R4");

        // R6 writes issued while busy are dropped
        run_write(6'd5, 40'h5555500000, 5, 4, 1, 0, 10, 1'b0, "R6");
        do_read(6'd40, 1'b1, 40'h0, "R6");
        do_read(6'd5, 1'b1, 40'h5555500000, "R6");

        // R7 read held during a write
        run_write(6'd7, 40'h7777777777, 4, 3, 2, 0, 8, 1'b0, "R7");

        // R5 timeout, then clearing by the next accepted write
        run_write(6'd12, 40'h0000000005, 2, 4, 4, 0, 255, 1'b1, "R5");
        do_read(6'd12, 1'b1, 40'h0, "R5");
        run_write(6'd12, 40'h0000000005, 2, 1, 0, 0, 4, 1'b0, "R5");

        // R8 out-of-range rows
        @(negedge clk);
        cpu_req = 1; cpu_we = 1; cpu_addr = 6'd52; cpu_wdata = 40'h1;
        @(negedge clk);
        cpu_req = 0;
        chk(cpu_ready == 1'b1, "R8 write to row 52 not started", 64'(cpu_ready), 64'd1);
        do_read(6'd63, 1'b0, 40'h0, "R8");

        // R1 reset during a write
        @(negedge clk);
        wlat_r = 50; cpu_req = 1; cpu_we = 1; cpu_addr = 6'd30; cpu_wdata = 40'hABCDE;
        @(negedge clk);
        cpu_req = 0;
        chk(cpu_ready == 1'b0, "R2 busy after accept", 64'(cpu_ready), 64'd0);
        chk(mem_wen == 1'b1, "R2 write drive on", 64'(mem_wen), 64'd1);
        repeat (4) @(negedge clk);
        rst = 1;
        repeat (2) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(cpu_ready == 1'b1, "R1 ready after mid-write reset", 64'(cpu_ready), 64'd1);
        chk(mem_wen == 1'b0, "R1 wen after mid-write reset", 64'(mem_wen), 64'd0);
        chk(cpu_err == 1'b0, "R1 err after mid-write reset", 64'(cpu_err), 64'd0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule